// File: doc/BRIEF.md
# Serial-In Shift Register With Bidirectional Storage Word

This block pairs a 16-bit serial-in shift register with a 16-bit storage word. Bits arrive one at a time on a serial input and move toward the top bit, which is driven on a serial output. The storage word drives a 16-bit parallel output. A transfer can copy the shift register into the storage word, or copy the storage word back into the shift register, so a word that was read in serially can be replayed out serially later.

The shift clock and the store clock are level inputs that are sampled on the system clock and are already synchronous to it. A falling transition of the shift clock, seen between two consecutive system clock edges, is one shift event. A rising transition of the store clock is one store event. An active-low select enables both registers. A read/write input chooses the direction of transfer, and the level of the store clock chooses whether a shift event shifts or reloads.

Top module: `shreg_store`

## Requirements
- R1: A synchronous active-high reset clears the shift register, the storage word and the edge history, so `ser_out` and `par_out` read 0 after reset.
- R2: The shift register changes only on a shift event, meaning `shift_clk` was 1 at the previous system clock edge and is 0 at this one. Rising transitions and steady levels of `shift_clk` have no effect.
- R3: A shift moves every bit up one place, loads `ser_in` into bit 0, and drops the old bit 15. `ser_out` always shows bit 15 of the shift register.
- R4: While `sel_n` is 1, the shift register holds, whatever the other inputs do.
- R5: With `sel_n` 0 and `rd_wr` 1, every shift event shifts, whatever the level of `store_clk`.
- R6: With `sel_n` 0, `rd_wr` 0 and `store_clk` 0, a shift event shifts.
- R7: With `sel_n` 0, `rd_wr` 0 and `store_clk` 1, a shift event copies the storage word into the shift register and does not shift.
- R8: The storage word holds whenever `sel_n` is 1 or `rd_wr` is 1, even on a store event.
- R9: With `sel_n` and `rd_wr` both 0, a store event copies the shift register into the storage word. The value copied is the one held before that same cycle, so a store event and a reloading shift event in one cycle exchange the two registers.
- R10: `par_out` always presents the storage word.
- R11: Each input transition takes effect at the first system clock edge that samples the new level, and only once, however long the level is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Select, active low |
| rd_wr | input | 1 | Transfer direction: 1 = shift only, 0 = transfers with storage |
| store_clk | input | 1 | Store strobe (rising transition = store event, high level = reload on shift) |
| shift_clk | input | 1 | Shift strobe (falling transition = shift event) |
| ser_in | input | 1 | Serial data into bit 0 |
| ser_out | output | 1 | Bit 15 of the shift register |
| par_out | output | 16 | Storage word |

## Verification
The shift path is driven with a mixed pattern (0xA5C3), then with runs of ones and zeros, and `ser_out` is compared after every event. This separates correct bit order from reversed or off-by-one shifting. Strobe levels are held for several cycles so that level-sensitive decoding can be told apart from edge detection. Every combination of select, direction and store level is applied, each to a register state that makes a shift, a reload and a hold give different outputs. A store event and a reloading shift event are also applied in the same cycle to show that both transfers use the values held before that cycle.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    // Operation applied to the shift register on one system clock
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_LOAD  = 2'd2
    } sh_op_e;

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic pulse
);

    logic hist_d, hist_q;
    logic armed_q;

    always_comb begin
        hist_d = strobe;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            hist_q  <= hist_d;
            armed_q <= 1'b1;
        end
    end

    generate
        if (RISING) begin : g_rise
            assign pulse = strobe & ~hist_q;
        end else begin : g_fall
            assign pulse = ~strobe & hist_q;
        end
    endgenerate

    // R11
    pulse_on_change_chk: assert property (@(posedge clk) disable iff (rst)
        armed_q && pulse |-> strobe != $past(strobe));

endmodule

// File: rtl/shift_stage.sv
module shift_stage
    import shreg_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  sh_op_e       op,
    input  logic         ser_in,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] word_q
);

    typedef struct packed {
        logic [W-1:0] word;
    } state_t;

    state_t state_d, state_q;
    logic   armed_q;

    always_comb begin
        state_d = state_q;
        case (op)
            OP_SHIFT: state_d.word = {state_q.word[W-2:0], ser_in};
            OP_LOAD:  state_d.word = load_val;
            default:  state_d.word = state_q.word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            armed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            armed_q <= 1'b1;
        end
    end

    assign word_q = state_q.word;

    // R3
    shift_moves_up_chk: assert property (@(posedge clk) disable iff (rst)
        armed_q && $past(op == OP_SHIFT) |->
            word_q == {$past(word_q[W-2:0]), $past(ser_in)});

    // R7
    reload_copies_chk: assert property (@(posedge clk) disable iff (rst)
        armed_q && $past(op == OP_LOAD) |-> word_q == $past(load_val));

endmodule

// File: rtl/store_stage.sv
module store_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic [W-1:0] in_word,
    output logic [W-1:0] word_q
);

    logic [W-1:0] word_d;
    logic [W-1:0] held_q;
    logic         armed_q;

    always_comb begin
        word_d = held_q;
        if (capture) begin
            word_d = in_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            held_q  <= word_d;
            armed_q <= 1'b1;
        end
    end

    assign word_q = held_q;

    // R8
    idle_keeps_word_chk: assert property (@(posedge clk) disable iff (rst)
        armed_q && !$past(capture) |-> $stable(word_q));

endmodule

// File: rtl/shreg_store.sv
module shreg_store
    import shreg_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sel_n,
    input  logic         rd_wr,
    input  logic         store_clk,
    input  logic         shift_clk,
    input  logic         ser_in,
    output logic         ser_out,
    output logic [W-1:0] par_out
);

    localparam int MSB = W - 1;

    logic         shift_fall;
    logic         store_rise;
    sh_op_e       op;
    logic         capture;
    logic [W-1:0] sreg_w;
    logic [W-1:0] store_w;
    logic         armed_q;

    strobe_edge #(.RISING(1'b0)) u_shift_edge (
        .clk    (clk),
        .rst    (rst),
        .strobe (shift_clk),
        .pulse  (shift_fall)
    );

    strobe_edge #(.RISING(1'b1)) u_store_edge (
        .clk    (clk),
        .rst    (rst),
        .strobe (store_clk),
        .pulse  (store_rise)
    );

    always_comb begin
        op = OP_HOLD;
        if (!sel_n && shift_fall) begin
            op = (!rd_wr && store_clk) ? OP_LOAD : OP_SHIFT;
        end
        capture = !sel_n && !rd_wr && store_rise;
    end

    shift_stage #(.W(W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .ser_in   (ser_in),
        .load_val (store_w),
        .word_q   (sreg_w)
    );

    store_stage #(.W(W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .in_word (sreg_w),
        .word_q  (store_w)
    );

    assign ser_out = sreg_w[MSB];
    assign par_out = store_w;

    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= 1'b1;
    end

    // R2
    no_event_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        armed_q && !$past(shift_fall) |-> $stable(sreg_w));

    // R4
    deselect_hold_chk: assert property (@(posedge clk) disable iff (rst)
        armed_q && $past(sel_n) |-> $stable(sreg_w) && $stable(par_out));

    // R8
    write_side_hold_chk: assert property (@(posedge clk) disable iff (rst)
        armed_q && $past(rd_wr) |-> $stable(par_out));

    // R9
    capture_old_word_chk: assert property (@(posedge clk) disable iff (rst)
        armed_q && $past(!sel_n && !rd_wr && store_rise) |-> par_out == $past(sreg_w));

endmodule

// File: tb/shreg_store_tb.sv
`timescale 1ns/1ps
module shreg_store_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1;
    logic        rd_wr = 1'b1;
    logic        store_clk = 1'b0;
    logic        shift_clk = 1'b0;
    logic        ser_in = 1'b0;
    logic        ser_out;
    logic [15:0] par_out;

    int n_run = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    shreg_store #(.W(16)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .sel_n     (sel_n),
        .rd_wr     (rd_wr),
        .store_clk (store_clk),
        .shift_clk (shift_clk),
        .ser_in    (ser_in),
        .ser_out   (ser_out),
        .par_out   (par_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one set of levels after a falling clock edge, sample after the next rising edge
    task automatic apply(input logic cs, input logic rw, input logic st,
                         input logic sh, input logic si);
        @(negedge clk);
        sel_n = cs; rd_wr = rw; store_clk = st; shift_clk = sh; ser_in = si;
        @(posedge clk);
        #1;
    endtask

    // Copy the shift register into the storage word, then read it back
    task automatic capture(input string req, input logic [15:0] exp);
        apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        check(req, par_out, exp);
        apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset;
        check("R1 ser_out", {15'd0, ser_out}, 16'd0);
        check("R1 par_out", par_out, 16'd0);
    endtask

    task automatic t_shift_pattern;
        logic [15:0] pat;
        logic [15:0] exp;
        pat = 16'hA5C3;
        exp = 16'd0;
        for (int i = 15; i >= 0; i--) begin
            apply(1'b0, 1'b1, 1'b0, 1'b1, pat[i]);
            check("R2 rising shift edge", {15'd0, ser_out}, {15'd0, exp[15]});
            apply(1'b0, 1'b1, 1'b0, 1'b0, pat[i]);
            exp = {exp[14:0], pat[i]};
            check("R3 serial out", {15'd0, ser_out}, {15'd0, exp[15]});
        end
        check("R10 storage untouched", par_out, 16'd0);
        capture("R9 capture pattern", 16'hA5C3);
    endtask

    task automatic t_levels;
        for (int i = 0; i < 4; i++) apply(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        check("R2 high level no shift", {15'd0, ser_out}, 16'd1);
        for (int i = 0; i < 4; i++) apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        capture("R11 R6 single shift", 16'h4B87);
    endtask

    task automatic t_deselect;
        apply(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        apply(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        apply(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R8 deselected store", par_out, 16'h4B87);
        check("R4 deselected ser_out", {15'd0, ser_out}, 16'd0);
        capture("R4 deselected hold", 16'h4B87);
    endtask

    task automatic t_write_side;
        apply(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        check("R8 store event with rd_wr high", par_out, 16'h4B87);
        check("R5 shift with store high", {15'd0, ser_out}, 16'd1);
        apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        capture("R5 shifted word", 16'h970F);
    endtask

    task automatic t_reload;
        logic [3:0] seq;
        for (int i = 0; i < 4; i++) begin
            apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
            apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        end
        check("R3 before reload", {15'd0, ser_out}, 16'd0);
        apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        apply(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R7 reload ser_out", {15'd0, ser_out}, 16'd1);
        check("R8 reload keeps storage", par_out, 16'h970F);
        apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        seq = 4'b1001;
        for (int i = 2; i >= 0; i--) begin
            apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
            apply(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
            check("R7 replayed bit", {15'd0, ser_out}, {15'd0, seq[i]});
        end
    endtask

    task automatic t_swap;
        apply(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R9 swap storage", par_out, 16'hB878);
        check("R9 swap ser_out", {15'd0, ser_out}, 16'd1);
        apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        capture("R9 swap shift word", 16'h970F);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        t_reset();
        t_shift_pattern();
        t_levels();
        t_deselect();
        t_write_side();
        t_reload();
        t_swap();
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_bad++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule